// File: doc/BRIEF.md
# Full-Speed USB Transmit Line Controller

This block is the full-speed transmit back end of a USB transceiver. A packet engine hands it bytes over a valid/ready handshake. The controller places a SYNC pattern on the bus, then sends each byte least significant bit first. It inserts a zero after long runs of ones and NRZI-encodes the result. When the engine withdraws its valid, the controller closes the packet with an end-of-packet pattern. Each line bit lasts a fixed number of local clocks, five by default.

PID and CRC bytes come from the engine as plain data. The outputs are the two single-ended drive levels and a drive enable. A two-bit mode input is captured when each packet starts. It selects one of three behaviours: normal encoding, a non-driving mode, or a raw mode that skips both stuffing and NRZI.

Top module: `usb_fs_tx`

## Requirements
- R1: After reset, and whenever no packet is in flight, `line_oe` is 0, the line shows J (`line_dp`=1, `line_dm`=0) and `tx_ready` is 0. K is `line_dp`=0, `line_dm`=1. SE0 is both low.
- R2: A packet starts at the first clock edge that samples `tx_valid` high while idle. The first SYNC symbol appears on the line one clock after that edge.
- R3: SYNC is the byte 0x80, sent LSB first and NRZI-encoded from idle J. On the line this gives K J K J K J K K. Every line symbol is held for `CLKS_PER_BIT` clocks.
- R4: Data bits go out LSB first, NRZI-encoded: a 0 switches between J and K, and a 1 keeps the previous level.
- R5: In modes 0 and 3, a 0 is inserted after every six consecutive ones. The closing 1 of SYNC counts toward the run. The insertion also happens after the last data bit, ahead of the end-of-packet pattern.
- R6: `tx_ready` is a registered pulse one clock wide. A byte is taken at each edge where `tx_valid` and `tx_ready` are both high. The first pulse comes in the clock right after the start edge. Each later pulse comes in the clock after the first bit of the previously taken byte has been put on the line.
- R7: A new byte is requested only once its predecessor starts on the line. Each inserted zero therefore delays the next request by one bit time, and eight inserted zeros withhold `tx_ready` for a whole byte time.
- R8: An edge that samples `tx_valid` low during a packet ends it, and `tx_ready` stays low from then on. After the last byte and any inserted zero, the line shows SE0 for two bit times and then J for one. `line_oe` then drops.
- R9: In mode 2, stuffing and NRZI are both off: a 1 drives J and a 0 drives K, and the end-of-packet pattern is unchanged.
- R10: In mode 1, `line_oe` stays 0 for the whole packet. The line levels and the handshake are the same as in mode 0.
- R11: The mode is captured at the start edge of each packet. A change on `op_mode` during a packet has no effect on that packet's line output or handshake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock, `CLKS_PER_BIT` cycles per line bit |
| rst | input | 1 | Synchronous active-high reset |
| tx_valid | input | 1 | Engine has a byte for the current packet; low ends the packet |
| tx_data | input | DATA_W | Byte offered by the engine |
| op_mode | input | 2 | 0 normal, 1 non-driving, 2 raw (no stuffing, no NRZI), 3 as normal |
| tx_ready | output | 1 | One-clock request: the byte on `tx_data` is taken at the next edge |
| line_dp | output | 1 | Positive line drive level |
| line_dm | output | 1 | Negative line drive level |
| line_oe | output | 1 | Line drive enable |

## Verification
The bench uses several packets to exercise stuffing. One has long runs of ones, which build up more than eight inserted zeros. Another ends its last byte on six ones. A design that miscounts the SYNC one would stuff one bit late. A design that skips the final insertion would start the end-of-packet pattern a bit early. Either error shifts every later symbol and every later ready pulse, and the clock-by-clock comparison catches the shift. Raw, non-driving and mid-packet mode changes are checked against the encoding fixed at the start edge. A separate line decoder recovers the bytes, so a wrong bit order or wrong NRZI sense shows up as corrupted data.

// File: rtl/usb_fs_tx_pkg.sv
`timescale 1ns/1ps
package usb_fs_tx_pkg;

  typedef enum logic [2:0] {
    ST_WAIT,
    ST_SYNC,
    ST_LOAD,
    ST_DWAIT,
    ST_EOP
  } tx_state_e;

  typedef enum logic [2:0] {
    CMD_NONE,
    CMD_BIT,
    CMD_SE0,
    CMD_EOPJ,
    CMD_OFF
  } line_cmd_e;

  localparam logic [1:0] MODE_NODRIVE = 2'd1;
  localparam logic [1:0] MODE_RAW     = 2'd2;

endpackage

// File: rtl/fstx_bit_timer.sv
`timescale 1ns/1ps
module fstx_bit_timer #(
  parameter int CLKS_PER_BIT = 5
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic tick
);
  localparam int CW = (CLKS_PER_BIT > 1) ? $clog2(CLKS_PER_BIT) : 1;
  localparam logic [CW-1:0] LAST = CW'(CLKS_PER_BIT - 1);

  logic [CW-1:0] cnt_q;

  assign tick = (cnt_q == LAST);

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= LAST;   // force a bit boundary on the next edge
    else if (tick)    cnt_q <= '0;
    else              cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/fstx_ctrl.sv
`timescale 1ns/1ps
module fstx_ctrl
  import usb_fs_tx_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int STUFF_RUN = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        op_mode,
  output logic              tx_ready,
  output logic              restart,
  output line_cmd_e         cmd,
  output logic              cmd_bit,
  output logic              raw_mode,
  output logic              drive_en,
  output tx_state_e         state
);
  localparam int BW = $clog2(DATA_W + 1);
  localparam int OW = $clog2(STUFF_RUN + 1);
  localparam logic [DATA_W-1:0] SYNC_PAT = {1'b1, {(DATA_W-1){1'b0}}};

  tx_state_e         st_q, st_n;
  logic [DATA_W-1:0] hold_q, hold_n, shreg_q, shreg_n;
  logic              hold_full_q, hold_full_n;
  logic [BW-1:0]     left_q, left_n;
  logic [OW-1:0]     ones_q, ones_n;
  logic              ending_q, ending_n;
  logic [1:0]        eop_q, eop_n, mode_q, mode_n;
  logic              ready_q, ready_n;
  logic              accept, active, stuff_en, load_ev;

  assign tx_ready = ready_q;
  assign state    = st_q;
  assign raw_mode = (mode_q == MODE_RAW);
  assign drive_en = (mode_q != MODE_NODRIVE);

  always_comb begin
    accept      = tx_valid && ready_q;
    active      = st_q inside {ST_SYNC, ST_LOAD, ST_DWAIT};
    stuff_en    = (mode_q != MODE_RAW);
    st_n        = st_q;
    hold_n      = accept ? tx_data : hold_q;
    hold_full_n = hold_full_q | accept;
    shreg_n     = shreg_q;
    left_n      = left_q;
    ones_n      = ones_q;
    ending_n    = ending_q | (active & ~tx_valid);
    eop_n       = eop_q;
    mode_n      = mode_q;
    restart     = 1'b0;
    cmd         = CMD_NONE;
    cmd_bit     = 1'b0;
    load_ev     = 1'b0;
    unique case (st_q)
      ST_WAIT: begin
        if (tx_valid) begin
          st_n        = ST_SYNC;
          shreg_n     = SYNC_PAT;
          left_n      = BW'(DATA_W);
          ones_n      = '0;
          ending_n    = 1'b0;
          hold_full_n = 1'b0;
          mode_n      = op_mode;
          restart     = 1'b1;
        end
      end
      ST_SYNC, ST_LOAD, ST_DWAIT: begin
        if (tick) begin
          if (stuff_en && ones_q == OW'(STUFF_RUN)) begin
            cmd     = CMD_BIT;
            cmd_bit = 1'b0;
            ones_n  = '0;
          end else if (left_q != '0) begin
            cmd     = CMD_BIT;
            cmd_bit = shreg_q[0];
            shreg_n = shreg_q >> 1;
            left_n  = left_q - 1'b1;
            ones_n  = shreg_q[0] ? ones_q + 1'b1 : '0;
          end else if (hold_full_q) begin
            cmd         = CMD_BIT;
            cmd_bit     = hold_q[0];
            shreg_n     = hold_q >> 1;
            left_n      = BW'(DATA_W - 1);
            ones_n      = hold_q[0] ? ones_q + 1'b1 : '0;
            hold_full_n = accept;
            load_ev     = 1'b1;
          end else begin
            cmd   = CMD_SE0;
            st_n  = ST_EOP;
            eop_n = 2'd1;
          end
        end
        if (st_n != ST_EOP)
          st_n = (st_q == ST_SYNC && !load_ev) ? ST_SYNC
               : (hold_full_n ? ST_DWAIT : ST_LOAD);
      end
      ST_EOP: begin
        if (tick) begin
          unique case (eop_q)
            2'd1:    begin cmd = CMD_SE0;  eop_n = 2'd2; end
            2'd2:    begin cmd = CMD_EOPJ; eop_n = 2'd3; end
            default: begin cmd = CMD_OFF;  eop_n = 2'd0; st_n = ST_WAIT; end
          endcase
        end
      end
      default: st_n = ST_WAIT;
    endcase
    ready_n = (st_n inside {ST_SYNC, ST_LOAD, ST_DWAIT}) && !hold_full_n && !ending_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q        <= ST_WAIT;
      hold_q      <= '0;
      hold_full_q <= 1'b0;
      shreg_q     <= '0;
      left_q      <= '0;
      ones_q      <= '0;
      ending_q    <= 1'b0;
      eop_q       <= 2'd0;
      mode_q      <= 2'd0;
      ready_q     <= 1'b0;
    end else begin
      st_q        <= st_n;
      hold_q      <= hold_n;
      hold_full_q <= hold_full_n;
      shreg_q     <= shreg_n;
      left_q      <= left_n;
      ones_q      <= ones_n;
      ending_q    <= ending_n;
      eop_q       <= eop_n;
      mode_q      <= mode_n;
      ready_q     <= ready_n;
    end
  end
endmodule

// File: rtl/fstx_line_enc.sv
`timescale 1ns/1ps
module fstx_line_enc
  import usb_fs_tx_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  line_cmd_e cmd,
  input  logic      cmd_bit,
  input  logic      raw_mode,
  input  logic      drive_en,
  output logic      line_dp,
  output logic      line_dm,
  output logic      line_oe
);
  logic lvl_q;   // 1 = J level
  logic lvl_n;

  always_comb begin
    if (raw_mode) lvl_n = cmd_bit;
    else          lvl_n = cmd_bit ? lvl_q : ~lvl_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lvl_q   <= 1'b1;
      line_dp <= 1'b1;
      line_dm <= 1'b0;
      line_oe <= 1'b0;
    end else begin
      unique case (cmd)
        CMD_BIT: begin
          lvl_q   <= lvl_n;
          line_dp <= lvl_n;
          line_dm <= ~lvl_n;
          line_oe <= drive_en;
        end
        CMD_SE0: begin
          line_dp <= 1'b0;
          line_dm <= 1'b0;
          line_oe <= drive_en;
        end
        CMD_EOPJ: begin
          lvl_q   <= 1'b1;
          line_dp <= 1'b1;
          line_dm <= 1'b0;
          line_oe <= drive_en;
        end
        CMD_OFF: begin
          lvl_q   <= 1'b1;
          line_dp <= 1'b1;
          line_dm <= 1'b0;
          line_oe <= 1'b0;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/usb_fs_tx.sv
`timescale 1ns/1ps
module usb_fs_tx
  import usb_fs_tx_pkg::*;
#(
  parameter int CLKS_PER_BIT = 5,
  parameter int DATA_W       = 8,
  parameter int STUFF_RUN    = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tx_valid,
  input  logic [DATA_W-1:0] tx_data,
  input  logic [1:0]        op_mode,
  output logic              tx_ready,
  output logic              line_dp,
  output logic              line_dm,
  output logic              line_oe
);
  logic      tick_w, restart_w, cmd_bit_w, raw_w, drv_w;
  line_cmd_e cmd_w;
  tx_state_e state_w;

  fstx_bit_timer #(.CLKS_PER_BIT(CLKS_PER_BIT)) timer_i (
    .clk(clk), .rst(rst), .restart(restart_w), .tick(tick_w)
  );

  fstx_ctrl #(.DATA_W(DATA_W), .STUFF_RUN(STUFF_RUN)) ctrl_i (
    .clk(clk), .rst(rst), .tick(tick_w), .tx_valid(tx_valid), .tx_data(tx_data),
    .op_mode(op_mode), .tx_ready(tx_ready), .restart(restart_w), .cmd(cmd_w),
    .cmd_bit(cmd_bit_w), .raw_mode(raw_w), .drive_en(drv_w), .state(state_w)
  );

  fstx_line_enc enc_i (
    .clk(clk), .rst(rst), .cmd(cmd_w), .cmd_bit(cmd_bit_w), .raw_mode(raw_w),
    .drive_en(drv_w), .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe)
  );
endmodule

// File: rtl/usb_fs_tx_checker.sv
`timescale 1ns/1ps
module usb_fs_tx_checker
  import usb_fs_tx_pkg::*;
(
  input logic      clk,
  input logic      rst,
  input logic      tx_valid,
  input logic      tx_ready,
  input logic      line_dp,
  input logic      line_dm,
  input logic      line_oe,
  input logic      bit_tick,
  input tx_state_e state
);
  AST_IDLE_NO_READY: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT) |-> !tx_ready); // R1

  AST_LINE_ON_BIT_EDGE: assert property (@(posedge clk) disable iff (rst)
    !bit_tick |=> $stable({line_dp, line_dm, line_oe})); // R3

  AST_NO_SE1: assert property (@(posedge clk) disable iff (rst)
    !(line_dp && line_dm)); // R4

  AST_READY_ONE_CLOCK: assert property (@(posedge clk) disable iff (rst)
    (tx_ready && tx_valid) |=> !tx_ready); // R6

  AST_NO_READY_AFTER_END: assert property (@(posedge clk) disable iff (rst)
    (!tx_valid && state != ST_WAIT) |=> !tx_ready); // R8

  AST_RELEASE_AFTER_J: assert property (@(posedge clk) disable iff (rst)
    $fell(line_oe) |-> (line_dp && !line_dm && $past(line_dp) && !$past(line_dm))); // R8
endmodule

bind usb_fs_tx usb_fs_tx_checker chk_i (
  .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_ready(tx_ready),
  .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe),
  .bit_tick(tick_w), .state(state_w)
);

// File: tb/usb_fs_tx_tb_top.sv
`timescale 1ns/1ps
module usb_fs_tx_tb_top;
  localparam int CPB = 5;
  localparam logic [1:0] SYM_J = 2'b10, SYM_K = 2'b01, SYM_SE0 = 2'b00;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       tx_valid = 1'b0;
  logic [7:0] tx_data = 8'h00;
  logic [1:0] op_mode = 2'd0;
  logic       tx_ready, line_dp, line_dm, line_oe;
  int errs = 0;
  int checks = 0;

  always #2.5 clk = ~clk;

  usb_fs_tx dut_i (
    .clk(clk), .rst(rst), .tx_valid(tx_valid), .tx_data(tx_data), .op_mode(op_mode),
    .tx_ready(tx_ready), .line_dp(line_dp), .line_dm(line_dm), .line_oe(line_oe)
  );

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic run_packet(input logic [1:0] m, input logic [7:0] b[$], input int chg_at,
                            input logic [1:0] m2, input string ltag, input string rtag);
    bit         raw[$];
    bit         sb[$];
    bit         isst[$];
    int         first_idx[$];
    logic [1:0] syms[$];
    logic [1:0] cap[$];
    bit         dec[$];
    int ones, n, lsym, dlen, k, acc, run, idx;
    bit pend, lvl, skip, bv;
    logic [1:0] exp_sym, prev;
    bit exp_oe, exp_rdy;
    string rq;
    n = b.size();
    for (int i = 0; i < 8; i++) raw.push_back(i == 7);
    foreach (b[j]) for (int i = 0; i < 8; i++) raw.push_back(b[j][i]);
    ones = 0;
    for (int r = 0; r < raw.size(); r++) begin
      if (r >= 8 && (r % 8) == 0) first_idx.push_back(sb.size());
      sb.push_back(raw[r]); isst.push_back(1'b0);
      if (m != 2'd2) begin
        ones = raw[r] ? ones + 1 : 0;
        if (ones == 6) begin sb.push_back(1'b0); isst.push_back(1'b1); ones = 0; end
      end
    end
    dlen = sb.size();
    lvl = 1'b1;
    foreach (sb[i]) begin
      if (m == 2'd2) lvl = sb[i];
      else if (!sb[i]) lvl = !lvl;
      syms.push_back(lvl ? SYM_J : SYM_K);
    end
    syms.push_back(SYM_SE0); syms.push_back(SYM_SE0); syms.push_back(SYM_J);
    lsym = syms.size();

    @(negedge clk);
    op_mode = m; tx_valid = 1'b1; tx_data = b[0];
    k = 0; acc = 0; pend = 1'b0;
    for (int rel = 0; rel < CPB * lsym + 10; rel++) begin
      @(negedge clk);
      if (rel == chg_at) op_mode = m2;
      idx = (rel - 1) / CPB;
      if (rel == 0 || idx >= lsym) begin exp_sym = SYM_J; exp_oe = 1'b0; end
      else begin exp_sym = syms[idx]; exp_oe = (m != 2'd1); end
      exp_rdy = (rel == 0);
      for (int q = 1; q < n; q++) if (rel == 1 + CPB * first_idx[q-1]) exp_rdy = 1'b1;
      if (ltag != "") rq = ltag;
      else if (rel <= 1) rq = "R2";
      else if (idx >= dlen) rq = "R8";
      else if (idx < 8) rq = "R3";
      else if (m == 2'd2) rq = "R9";
      else if (isst[idx]) rq = "R5";
      else rq = "R4";
      chk({line_dp, line_dm} == exp_sym, rq, "line symbol", {line_dp, line_dm}, exp_sym);
      chk(line_oe == exp_oe, (ltag != "") ? ltag : ((m == 2'd1) ? "R10" : "R8"), "output enable",
          line_oe, exp_oe);
      chk(tx_ready == exp_rdy, rtag, "tx_ready", tx_ready, exp_rdy);
      if (rel >= 1 && ((rel - 1) % CPB) == 2 && idx < lsym) cap.push_back({line_dp, line_dm});
      if (pend) begin
        k++;
        if (k < n) tx_data = b[k];
        else begin tx_valid = 1'b0; tx_data = 8'h00; end
        pend = 1'b0;
      end
      if (tx_valid && tx_ready) begin pend = 1'b1; acc++; end
    end
    op_mode = 2'd0;
    chk(acc == n, rtag, "bytes taken", acc, n);
    if (m != 2'd2) begin
      prev = SYM_J; run = 0; skip = 1'b0;
      foreach (cap[i]) begin
        if (cap[i] == SYM_SE0) break;
        bv = (cap[i] == prev);
        prev = cap[i];
        if (skip) begin
          skip = 1'b0;
          chk(bv == 1'b0, "R5", "decoded stuffed bit", bv, 0);
        end else begin
          dec.push_back(bv);
          run = bv ? run + 1 : 0;
          if (run == 6) begin skip = 1'b1; run = 0; end
        end
      end
      chk(dec.size() == 8 * (n + 1), "R4", "decoded bit count", dec.size(), 8 * (n + 1));
      if (dec.size() == 8 * (n + 1)) begin
        for (int j = 0; j <= n; j++) begin
          logic [7:0] got;
          for (int i = 0; i < 8; i++) got[i] = dec[8*j + i];
          if (j == 0) chk(got == 8'h80, "R3", "decoded SYNC", got, 8'h80);
          else        chk(got == b[j-1], "R4", "decoded byte", got, b[j-1]);
        end
      end
    end
  endtask

  initial begin
    logic [7:0] pk[$];
    repeat (4) @(negedge clk);
    rst = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      chk({line_dp, line_dm} == SYM_J, "R1", "idle line", {line_dp, line_dm}, SYM_J);
      chk(line_oe == 1'b0, "R1", "idle enable", line_oe, 0);
      chk(tx_ready == 1'b0, "R1", "idle ready", tx_ready, 0);
    end
    pk = '{8'hC3, 8'h5A};                          run_packet(2'd0, pk, -1, 2'd0, "", "R6");
    pk = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF};
    run_packet(2'd0, pk, -1, 2'd0, "", "R7");
    pk = '{8'h00, 8'hFC};                          run_packet(2'd0, pk, -1, 2'd0, "", "R6");
    pk = '{8'hFF, 8'h01};                          run_packet(2'd2, pk, -1, 2'd0, "", "R6");
    pk = '{8'h3C, 8'hF0};                          run_packet(2'd1, pk, -1, 2'd0, "", "R10");
    pk = '{8'hFF, 8'hFF, 8'hA5};                   run_packet(2'd0, pk, 20, 2'd2, "R11", "R11");
    pk = '{8'h7E};                                 run_packet(2'd3, pk, -1, 2'd0, "", "R6");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errs++; checks++;
    $display("FAIL R6 watchdog: actual=timeout expected=completion");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule